// File: doc/BRIEF.md
# Inter-processor message mailbox

The block is a memory-mapped mailbox through which processors sharing a chip exchange 32-bit words. It contains several independent first-in first-out message queues and serves several users. Each user has its own interrupt status register, its own interrupt enable register and its own interrupt output. A processor sends by writing a queue's message register and receives by reading that same register. Per-queue status registers report whether the queue is full and how many words it holds.

Each queue produces two interrupt events. One marks a newly accepted word. The other marks the queue leaving the full state. Every event is posted to every user's status register, and each user enables only the events it cares about. Software acknowledges an event by writing a one to its status bit. A small configuration register and a reset-done status register complete the map. All register reads return their data one clock after the request.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty (count register 0, full register 0), every status and enable register reads 0, the configuration register reads 0, every `irq_o` bit is 0 and `bus_rdata_o` is 0.
- R2: A write to the message register of queue m (byte address 0x040+4m) appends the word. A read of that register returns the oldest word and removes it, in first-in first-out order. Read data appears on `bus_rdata_o` on the clock after the read request.
- R3: The count register of queue m (0x0C0+4m) returns the number of words held. The full register of queue m (0x080+4m) returns 1 when the queue holds DEPTH words and 0 otherwise.
- R4: A write to a full queue is dropped and leaves its contents and count unchanged. A read of an empty queue returns 0 and leaves the queue unchanged.
- R5: Every accepted push into queue m sets bit 2m of the status register of every user u (0x100+8u).
- R6: A pop that takes queue m from full to not full sets bit 2m+1 of every user's status register.
- R7: Writing a one to a status bit clears it. Writing a zero leaves the bit unchanged.
- R8: The enable register of user u (0x104+8u) is read/write. `irq_o[u]` equals the OR of (status AND enable) for user u, and it follows a change of status or enable on the same clock edge that changes the register.
- R9: The identity register (0x000) reads 0x00000201. The configuration register (0x010) stores bits 0 and 4 and reads all other bits as 0. The reset-status register (0x014) reads 0x00000001.
- R10: Writes to the identity, reset-status, full and count registers have no effect on their read values or on any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data, valid the cycle after a read |
| irq_o | output | NUM_U | One interrupt line per user |

## Verification
The queues are exercised with short bursts that are popped back in order, which catches pointer and ordering faults. They are also filled to capacity and pushed once more, which separates a dropped overflow from a wrapped pointer. Reads of an empty queue show whether the read pointer moves when it should not. Status and enable traffic shows that acknowledge bits only clear and that enables gate each user's line separately. A long mixed phase of random pushes, pops, acknowledges and enable writes over all queues and users is compared against a behavioural model on every clock, which brings out interactions that the directed cases miss.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam logic [31:0] MBOX_REVISION = 32'h0000_0201;
  localparam logic [31:0] SYSCFG_MASK   = 32'h0000_0011;
  localparam logic [31:0] SYSSTAT_DONE  = 32'h0000_0001;
  localparam int ADDR_REV     = 'h000;
  localparam int ADDR_SYSCFG  = 'h010;
  localparam int ADDR_SYSSTAT = 'h014;
  // Region selectors on address bits above bit 6 (queues) and bit 8 (users)
  localparam int REG_Q_MSG   = 1;
  localparam int REG_Q_FULL  = 2;
  localparam int REG_Q_COUNT = 3;
  localparam int REG_USER    = 1;
endpackage

// File: rtl/ipc_mbox_queue.sv
module ipc_mbox_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         pushed_o,
  output logic                         unfull_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == PW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o   = mem[rptr_q];
  assign count_o  = cnt_q;
  assign pushed_o = do_push;
  assign unfull_o = do_pop && full_o && !do_push;

  // R4: a push into a full queue leaves the count alone
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full_o) |=> $stable(cnt_q));
  // R4: a pop from an empty queue leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty) |=> (cnt_q == '0));
  // R3: count never moves without a request
  a_r3_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] ev_i,
  input  logic [EVW-1:0] clr_i,
  input  logic           en_we_i,
  input  logic [EVW-1:0] en_i,
  output logic [EVW-1:0] status_o,
  output logic [EVW-1:0] enable_o,
  output logic           irq_o
);
  logic [EVW-1:0] status_q, enable_q, status_n, enable_n;
  logic           irq_q;

  assign status_n = (status_q & ~clr_i) | ev_i;
  assign enable_n = en_we_i ? en_i : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      enable_q <= enable_n;
      irq_q    <= |(status_n & enable_n);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  // R5/R6: a posted event is visible the next cycle
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i)));
  // R7: a one written without a new event clears the bit
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~ev_i) != '0) |=> ((status_q & $past(clr_i & ~ev_i)) == '0));
  // R7: no clear request means no bit drops
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R8: line matches enabled status
  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & enable_q));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int NUM_U = 4,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic [NUM_U-1:0] irq_o
);
  localparam int EVW = 2 * NUM_Q;
  localparam int CW  = $clog2(DEPTH+1);
  localparam int QSW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int USW = (NUM_U > 1) ? $clog2(NUM_U) : 1;

  logic [NUM_Q-1:0][DW-1:0] q_head;
  logic [NUM_Q-1:0][CW-1:0] q_cnt;
  logic [NUM_Q-1:0]         q_full, q_pushed, q_unfull;
  logic [EVW-1:0]           events;
  logic [NUM_U-1:0][EVW-1:0] u_stat, u_en;
  logic [DW-1:0]            rd_val, rdata_q, cfg_q;
  logic                     q_idx_ok, u_idx_ok, msg_hit, full_hit, cnt_hit, usr_hit;
  logic [QSW-1:0]           q_sel;
  logic [USW-1:0]           u_sel;
  logic                     rd_msg;
  logic                     unused_bits;

  assign unused_bits = ^bus_addr_i[1:0];

  // address decode
  assign q_idx_ok = int'(bus_addr_i[5:2]) < NUM_Q;
  assign u_idx_ok = int'(bus_addr_i[7:3]) < NUM_U;
  assign q_sel    = bus_addr_i[2 +: QSW];
  assign u_sel    = bus_addr_i[3 +: USW];
  assign msg_hit  = (bus_addr_i[AW-1:6] == (AW-6)'(REG_Q_MSG))   && q_idx_ok;
  assign full_hit = (bus_addr_i[AW-1:6] == (AW-6)'(REG_Q_FULL))  && q_idx_ok;
  assign cnt_hit  = (bus_addr_i[AW-1:6] == (AW-6)'(REG_Q_COUNT)) && q_idx_ok;
  assign usr_hit  = (bus_addr_i[AW-1:8] == (AW-8)'(REG_USER))    && u_idx_ok;
  assign rd_msg   = bus_sel_i && !bus_we_i && msg_hit;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic this_q;
    assign this_q = msg_hit && (int'(bus_addr_i[5:2]) == q);
    ipc_mbox_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
      .clk      (clk),
      .rst      (rst),
      .push_i   (bus_sel_i && bus_we_i && this_q),
      .pop_i    (bus_sel_i && !bus_we_i && this_q),
      .wdata_i  (bus_wdata_i),
      .head_o   (q_head[q]),
      .count_o  (q_cnt[q]),
      .full_o   (q_full[q]),
      .pushed_o (q_pushed[q]),
      .unfull_o (q_unfull[q])
    );
    assign events[2*q]   = q_pushed[q];
    assign events[2*q+1] = q_unfull[q];
  end

  for (genvar u = 0; u < NUM_U; u++) begin : g_user
    logic this_u;
    assign this_u = bus_sel_i && bus_we_i && usr_hit && (int'(bus_addr_i[7:3]) == u);
    ipc_mbox_irq #(.EVW(EVW)) u_irq (
      .clk      (clk),
      .rst      (rst),
      .ev_i     (events),
      .clr_i    ((this_u && !bus_addr_i[2]) ? bus_wdata_i[EVW-1:0] : '0),
      .en_we_i  (this_u && bus_addr_i[2]),
      .en_i     (bus_wdata_i[EVW-1:0]),
      .status_o (u_stat[u]),
      .enable_o (u_en[u]),
      .irq_o    (irq_o[u])
    );
  end

  // configuration register: only the masked bits are stored
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (bus_sel_i && bus_we_i && bus_addr_i == AW'(ADDR_SYSCFG))
      cfg_q <= bus_wdata_i & DW'(SYSCFG_MASK);
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr_i == AW'(ADDR_REV))          rd_val = DW'(MBOX_REVISION);
    else if (bus_addr_i == AW'(ADDR_SYSCFG))  rd_val = cfg_q;
    else if (bus_addr_i == AW'(ADDR_SYSSTAT)) rd_val = DW'(SYSSTAT_DONE);
    else if (msg_hit)  rd_val = (q_cnt[q_sel] == '0) ? '0 : q_head[q_sel];
    else if (full_hit) rd_val = DW'(q_full[q_sel]);
    else if (cnt_hit)  rd_val = DW'(q_cnt[q_sel]);
    else if (usr_hit)  rd_val = bus_addr_i[2] ? DW'(u_en[u_sel]) : DW'(u_stat[u_sel]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_sel_i && !bus_we_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;

  // R4: reading an empty queue yields zero on the following cycle
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_msg && q_cnt[q_sel] == '0) |=> (bus_rdata_o == '0));
  // R2: read data only changes after a read request
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int NQ  = 4;
  localparam int DEP = 4;
  localparam int NU  = 4;
  localparam logic [31:0] REV = 32'h0000_0201;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NU-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;

  // behavioural model
  int          mcnt [NQ];
  logic [31:0] mdat [NQ][DEP];
  logic [7:0]  mst  [NU];
  logic [7:0]  men  [NU];
  logic [31:0] mcfg;

  always #10 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst(rst), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic post_event(input int bitn);
    for (int u = 0; u < NU; u++) mst[u][bitn] = 1'b1;
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h040 && a < 12'h040 + 4*NQ) begin
      int q = (a - 12'h040) >> 2;
      if (mcnt[q] < DEP) begin
        mdat[q][mcnt[q]] = d;
        mcnt[q]++;
        post_event(2*q);
      end
    end else if (a >= 12'h100 && a < 12'h100 + 8*NU) begin
      int u = (a - 12'h100) >> 3;
      if (a[2]) men[u] = d[7:0];
      else      mst[u] = mst[u] & ~d[7:0];
    end else if (a == 12'h010) begin
      mcfg = d & 32'h11;
    end
  endtask

  task automatic model_rd(input logic [11:0] a, output logic [31:0] v);
    v = '0;
    if (a == 12'h000) v = REV;
    else if (a == 12'h010) v = mcfg;
    else if (a == 12'h014) v = 32'h1;
    else if (a >= 12'h040 && a < 12'h040 + 4*NQ) begin
      int q = (a - 12'h040) >> 2;
      if (mcnt[q] > 0) begin
        bit was_full = (mcnt[q] == DEP);
        v = mdat[q][0];
        for (int k = 0; k < DEP-1; k++) mdat[q][k] = mdat[q][k+1];
        mcnt[q]--;
        if (was_full) post_event(2*q+1);
      end
    end
    else if (a >= 12'h080 && a < 12'h080 + 4*NQ) v = (mcnt[(a-12'h080)>>2] == DEP) ? 32'h1 : 32'h0;
    else if (a >= 12'h0C0 && a < 12'h0C0 + 4*NQ) v = 32'(mcnt[(a-12'h0C0)>>2]);
    else if (a >= 12'h100 && a < 12'h100 + 8*NU) begin
      int u = (a - 12'h100) >> 3;
      v = a[2] ? {24'h0, men[u]} : {24'h0, mst[u]};
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    sel = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    model_rd(a, exp);
    @(negedge clk);
    sel = 1'b0;
    check(tag, rdata, exp);
  endtask

  // R8: every clock, each interrupt line against the model
  always @(negedge clk) begin
    if (chk_on) begin
      for (int u = 0; u < NU; u++)
        check("R8 irq line", 32'(irq[u]), 32'(|(mst[u] & men[u])));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) mcnt[q] = 0;
    for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
    mcfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1: reset state
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
    for (int q = 0; q < NQ; q++) begin
      rd(12'h0C0 + 12'(4*q), "R1 count zero");
      rd(12'h080 + 12'(4*q), "R1 full zero");
    end
    for (int u = 0; u < NU; u++) begin
      rd(12'h100 + 12'(8*u), "R1 status zero");
      rd(12'h104 + 12'(8*u), "R1 enable zero");
    end
    rd(12'h010, "R1 config zero");

    // R9: identity, config mask, reset status
    rd(12'h000, "R9 identity");
    rd(12'h014, "R9 reset status");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, "R9 config masked");

    // R2 / R3: FIFO order and count
    wr(12'h040, 32'hA000_0001);
    wr(12'h040, 32'hA000_0002);
    wr(12'h040, 32'hA000_0003);
    rd(12'h0C0, "R3 count three");
    rd(12'h100, "R5 new-message bit user0");
    rd(12'h118, "R5 new-message bit user3");
    rd(12'h040, "R2 first word");
    rd(12'h040, "R2 second word");
    rd(12'h040, "R2 third word");
    rd(12'h0C0, "R3 count empty");

    // R4 / R6: fill queue 1, overflow, then leave full
    for (int k = 0; k < DEP; k++) wr(12'h044, 32'hB000_0000 + 32'(k));
    rd(12'h084, "R3 full flag set");
    wr(12'h044, 32'hDEAD_BEEF);
    rd(12'h0C4, "R4 overflow dropped count");
    rd(12'h108, "R6 not-full bit still clear");
    rd(12'h044, "R6 pop from full");
    rd(12'h108, "R6 not-full bit set user1");
    rd(12'h084, "R3 full flag clear");
    for (int k = 1; k < DEP; k++) rd(12'h044, "R4 no overwritten word");
    rd(12'h044, "R4 empty read zero");
    rd(12'h0C4, "R4 empty count stays");
    rd(12'h048, "R4 never-used queue empty read");

    // R7 / R8: acknowledge and enable
    wr(12'h10C, 32'h0000_0001);
    check("R8 user1 line on", 32'(irq[1]), 32'h1);
    check("R8 user0 line off", 32'(irq[0]), 32'h0);
    wr(12'h108, 32'h0000_0000);
    rd(12'h108, "R7 zero write keeps");
    wr(12'h108, 32'h0000_0001);
    rd(12'h108, "R7 one write clears");
    check("R8 user1 line off after ack", 32'(irq[1]), 32'h0);
    rd(12'h10C, "R8 enable readback");

    // R10: writes to read-only registers
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0);
    wr(12'h080, 32'h1);
    wr(12'h0C0, 32'h3);
    rd(12'h000, "R10 identity unchanged");
    rd(12'h014, "R10 reset status unchanged");
    rd(12'h080, "R10 full unchanged");
    rd(12'h0C0, "R10 count unchanged");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int q = $urandom_range(NQ-1);
      int u = $urandom_range(NU-1);
      case ($urandom_range(6))
        0, 1: wr(12'h040 + 12'(4*q), $urandom);
        2:    rd(12'h040 + 12'(4*q), "R2 mixed pop");
        3:    rd(12'h0C0 + 12'(4*q), "R3 mixed count");
        4:    wr(12'h100 + 12'(8*u), 32'($urandom_range(255)));
        5:    wr(12'h104 + 12'(8*u), 32'($urandom_range(255)));
        default: rd(12'h100 + 12'(8*u), "R5 mixed status");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule